// File: doc/BRIEF.md
# Transmit Descriptor Processor

This block is the transmit half of a descriptor-driven Ethernet DMA engine. Software builds a ring of four-word descriptors in shared memory. Each descriptor holds a status word, a control word, a buffer address and a pointer to the next descriptor. The host sets the ownership bit and then strobes the poll input. If transmit is enabled, the engine walks the ring. It streams each owned buffer one byte per accepted handshake to a MAC byte interface and appends zero padding to short frames when that is asked for. It waits for the MAC to report the outcome, writes a status word back to the descriptor, which hands the descriptor back to the host, and moves on to the next one. The walk stops at the first descriptor the host still owns. The engine flags that event and returns to idle.

Memory reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. Writes take effect at the clock edge on which `mem_we` is high. All addresses are byte addresses, and words are 32 bits, little-endian: the byte at the lowest address is sent first.

The controller is a single state machine with these states:
- IDLE: waits for a poll. While transmit is disabled, the ring pointer follows `ring_base`.
- IDLE → RD_STAT: on a poll while transmit is enabled.
- RD_STAT: reads the status word. If the descriptor is owned, the next state is RD_CTRL. If the host owns it, a buffer-unavailable pulse is raised and the next state is IDLE.
- RD_CTRL → RD_BUF → RD_NEXT: fetch the remaining descriptor words.
- RD_NEXT: goes to STREAM if the byte count is nonzero. A zero count takes the end-of-buffer route described below.
- STREAM: sends the buffer bytes. After the final byte it takes the end-of-buffer route:
  - a descriptor that is not last goes to WR_STAT;
  - a last descriptor that needs padding goes to PAD;
  - any other last descriptor goes to WAIT_MAC.
- PAD → WAIT_MAC: once the frame reaches 60 bytes.
- WAIT_MAC → WR_STAT: on `mac_done`.
- WR_STAT: writes the status word back and follows the next pointer. It goes to RD_STAT while transmit is still enabled, and to IDLE otherwise.

Top module: `txdesc_engine`

## Requirements
- R1: After reset the engine is idle: `mac_valid`, `mem_we`, `tx_done`, `tx_early` and `tx_buf_unavail` are all 0.
- R2: A poll while `tx_enable` is 0 is ignored: no memory write, no byte sent, no buffer-unavailable pulse. While disabled and idle, the ring pointer is reloaded from `ring_base`.
- R3: On a poll the status word at the ring pointer is read; bit 31 set means the engine owns the descriptor and processes it. With bit 31 clear, `tx_buf_unavail` pulses for one cycle, nothing is sent, and the engine returns to idle.
- R4: Descriptor layout: status word at offset 0, control word at 4, buffer address at 8, next pointer at 12. Control bits: 31 done interrupt, 30 early interrupt, 29 last, 28 first, 27 CRC append, 26 pad, 25 retry on late collision, 21:11 packet size, 10:0 buffer byte count.
- R5: The engine sends exactly the buffer byte count of bytes from the buffer address, with the lowest address first within a word. `mac_data` and `mac_last` stay stable while `mac_valid` is high and `mac_ready` is low.
- R6: On a last descriptor with the pad bit set, a frame shorter than 60 bytes is extended with zero bytes to exactly 60. Without the pad bit, or at 60 bytes or more, no byte is added.
- R7: `mac_first` marks only the first byte of a frame that started with a first-flagged descriptor. `mac_last` marks only the final byte, padding included.
- R8: After the final byte the engine waits for `mac_done` and then writes the status word. In that word, bit 31 is 0 and the following bits are set:
  - bit 13: carrier lost;
  - bit 12: late collision;
  - bit 11: excessive collisions, meaning a collision count of 16 or more;
  - bit 10: underflow;
  - bits 7:0: the collision count.
  Bits 14, 9 and 8 are 0. A descriptor that is not last gets a status of 0 written back.
- R9: `tx_done` pulses for one cycle, together with the write-back of a last descriptor, only if control bit 31 of that descriptor is set.
- R10: `tx_early` pulses once, when the first byte of a descriptor with control bit 30 set is accepted.
- R11: After each write-back the engine follows the next pointer and fetches that descriptor without a new poll, until it finds one owned by the host.
- R12: The CRC enable, the late-collision retry flag and the packet size are taken from the frame's first descriptor. They are presented on `mac_crc_en`, `mac_retry_lc` and `mac_pkt_len` while the frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Transmit enable |
| tx_poll | input | 1 | Poll-demand strobe |
| ring_base | input | 32 | Byte address of the first ring descriptor |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational on mem_addr |
| mac_valid | output | 1 | Byte valid towards the MAC |
| mac_data | output | 8 | Frame byte |
| mac_first | output | 1 | First byte of the frame |
| mac_last | output | 1 | Final byte of the frame |
| mac_ready | input | 1 | MAC accepts the byte |
| mac_crc_en | output | 1 | MAC should append CRC |
| mac_retry_lc | output | 1 | MAC may retry after a late collision |
| mac_pkt_len | output | 11 | Packet size from the first descriptor |
| mac_done | input | 1 | MAC finished the frame |
| mac_coll_cnt | input | 8 | Collision retries used |
| mac_late_col | input | 1 | Late collision seen |
| mac_carrier_lost | input | 1 | Carrier lost during the frame |
| mac_underflow | input | 1 | FIFO underflow |
| tx_done | output | 1 | Frame-done interrupt pulse |
| tx_early | output | 1 | Early-transmit interrupt pulse |
| tx_buf_unavail | output | 1 | Host-owned descriptor found |

## Verification
A table of single-descriptor frames varies four things: the length around the 60-byte bound (1, 10, 59, 60 and 64), the pad bit, the MAC ready pattern and the reported error mix. This separates correct padding from off-by-one padding, and it separates status packing errors, including the 16-collision threshold, from stream errors. A two-descriptor chain shows that the frame is stitched across buffers, that only the last descriptor reports errors or raises the done pulse, and that the walk continues without a poll. Directed cases cover these conditions:
- a poll while disabled;
- a host-owned descriptor;
- a zero-length padded buffer;
- a frame with the early-interrupt bit set and the done-interrupt bit clear.

Another directed case reloads the pointer after a chain has left it elsewhere, which shows that disabling the engine returns the ring to its base.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int OWN_BIT = 31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_CTRL,
        S_RD_BUF,
        S_RD_NEXT,
        S_STREAM,
        S_PAD,
        S_WAIT_MAC,
        S_WR_STAT
    } txd_state_t;

    typedef struct packed {
        logic        irq;
        logic        early;
        logic        last;
        logic        first;
        logic        crc;
        logic        pad;
        logic        retry_lc;
        logic [10:0] pkt_len;
        logic [10:0] buf_len;
    } txd_ctrl_t;

    typedef struct packed {
        logic       carrier_lost;
        logic       late_col;
        logic       underflow;
        logic [7:0] coll;
    } txd_result_t;

endpackage

// File: rtl/txd_ctrl_decode.sv
module txd_ctrl_decode
    import txd_pkg::*;
(
    input  logic [31:0] word,
    output txd_ctrl_t   ctrl
);
    logic [3:0] unused_gap;

    always_comb begin
        ctrl.irq      = word[31];
        ctrl.early    = word[30];
        ctrl.last     = word[29];
        ctrl.first    = word[28];
        ctrl.crc      = word[27];
        ctrl.pad      = word[26];
        ctrl.retry_lc = word[25];
        ctrl.pkt_len  = word[21:11];
        ctrl.buf_len  = word[10:0];
        unused_gap    = word[24:21] & 4'b0000;
    end
endmodule

// File: rtl/txd_status_pack.sv
module txd_status_pack
    import txd_pkg::*;
#(
    parameter int EXC_COLL = 16
) (
    input  txd_result_t res,
    input  logic        last_desc,
    output logic [31:0] word
);
    localparam logic [7:0] EXC_LIMIT = 8'(EXC_COLL);

    logic excessive;

    always_comb begin
        excessive = (res.coll >= EXC_LIMIT);
        if (last_desc) begin
            word = {17'd0, 1'b0, res.carrier_lost, res.late_col, excessive,
                    res.underflow, 2'b00, res.coll};
        end else begin
            word = 32'd0;
        end
    end
endmodule

// File: rtl/txd_byte_lane.sv
module txd_byte_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   lane,
    output logic [7:0]                 byte_o
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MIN_FRAME = 60,
    parameter int EXC_COLL  = 16,
    parameter int BLW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic          tx_poll,
    input  logic [AW-1:0] ring_base,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          mac_valid,
    output logic [7:0]    mac_data,
    output logic          mac_first,
    output logic          mac_last,
    input  logic          mac_ready,
    output logic          mac_crc_en,
    output logic          mac_retry_lc,
    output logic [10:0]   mac_pkt_len,
    input  logic          mac_done,
    input  logic [7:0]    mac_coll_cnt,
    input  logic          mac_late_col,
    input  logic          mac_carrier_lost,
    input  logic          mac_underflow,
    output logic          tx_done,
    output logic          tx_early,
    output logic          tx_buf_unavail
);
    localparam int            FCW      = BLW + 1;
    localparam logic [FCW-1:0] MIN_CNT  = FCW'(MIN_FRAME);
    localparam logic [FCW-1:0] MIN_LAST = FCW'(MIN_FRAME - 1);
    localparam logic [AW-1:0]  OFS_CTRL = AW'(4);
    localparam logic [AW-1:0]  OFS_BUF  = AW'(8);
    localparam logic [AW-1:0]  OFS_NEXT = AW'(12);

    txd_state_t  state, state_nx;
    txd_ctrl_t   ctrl_dec, ctrl_q;
    txd_result_t res_q;

    logic [AW-1:0]  cur_ptr, buf_q, next_q, stream_addr;
    logic [BLW-1:0] idx;
    logic [FCW-1:0] frame_cnt, cnt_inc;
    logic [31:0]    status_word;
    logic [7:0]     lane_byte;
    logic           at_end, pad_after;

    txd_ctrl_decode u_dec (
        .word (mem_rdata),
        .ctrl (ctrl_dec)
    );

    txd_status_pack #(.EXC_COLL(EXC_COLL)) u_pack (
        .res       (res_q),
        .last_desc (ctrl_q.last),
        .word      (status_word)
    );

    txd_byte_lane #(.LANES(4)) u_lane (
        .word   (mem_rdata),
        .lane   (stream_addr[1:0]),
        .byte_o (lane_byte)
    );

    assign stream_addr = buf_q + AW'(idx);
    assign cnt_inc     = frame_cnt + 1'b1;
    assign at_end      = (idx == ctrl_q.buf_len - 1'b1);
    assign pad_after   = ctrl_q.pad && (cnt_inc < MIN_CNT);

    // End-of-buffer routing for a given frame byte count
    function automatic txd_state_t route(input logic last, input logic pad,
                                         input logic [FCW-1:0] cnt);
        if (!last)                     return S_WR_STAT;
        else if (pad && cnt < MIN_CNT) return S_PAD;
        else                           return S_WAIT_MAC;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (tx_poll && tx_enable) state_nx = S_RD_STAT;
            S_RD_STAT:  state_nx = mem_rdata[OWN_BIT] ? S_RD_CTRL : S_IDLE;
            S_RD_CTRL:  state_nx = S_RD_BUF;
            S_RD_BUF:   state_nx = S_RD_NEXT;
            S_RD_NEXT:  state_nx = (ctrl_q.buf_len != '0) ? S_STREAM
                                 : route(ctrl_q.last, ctrl_q.pad, frame_cnt);
            S_STREAM:   if (mac_ready && at_end)
                            state_nx = route(ctrl_q.last, ctrl_q.pad, cnt_inc);
            S_PAD:      if (mac_ready && frame_cnt == MIN_LAST) state_nx = S_WAIT_MAC;
            S_WAIT_MAC: if (mac_done) state_nx = S_WR_STAT;
            S_WR_STAT:  state_nx = tx_enable ? S_RD_STAT : S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_addr       = cur_ptr;
        mem_we         = 1'b0;
        mem_wdata      = status_word;
        mac_valid      = 1'b0;
        mac_data       = 8'd0;
        mac_last       = 1'b0;
        tx_done        = 1'b0;
        tx_early       = 1'b0;
        tx_buf_unavail = 1'b0;
        unique case (state)
            S_IDLE:     ;
            S_RD_STAT:  tx_buf_unavail = !mem_rdata[OWN_BIT];
            S_RD_CTRL:  mem_addr = cur_ptr + OFS_CTRL;
            S_RD_BUF:   mem_addr = cur_ptr + OFS_BUF;
            S_RD_NEXT:  mem_addr = cur_ptr + OFS_NEXT;
            S_STREAM: begin
                mem_addr  = {stream_addr[AW-1:2], 2'b00};
                mac_valid = 1'b1;
                mac_data  = lane_byte;
                mac_last  = ctrl_q.last && at_end && !pad_after;
                tx_early  = ctrl_q.early && (idx == '0) && mac_ready;
            end
            S_PAD: begin
                mac_valid = 1'b1;
                mac_last  = (frame_cnt == MIN_LAST);
            end
            S_WAIT_MAC: ;
            S_WR_STAT: begin
                mem_we  = 1'b1;
                tx_done = ctrl_q.last && ctrl_q.irq;
            end
            default: ;
        endcase
    end

    assign mac_first = (state == S_STREAM || state == S_PAD) && (frame_cnt == '0);

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr      <= '0;
            ctrl_q       <= '0;
            buf_q        <= '0;
            next_q       <= '0;
            idx          <= '0;
            frame_cnt    <= '0;
            res_q        <= '0;
            mac_crc_en   <= 1'b0;
            mac_retry_lc <= 1'b0;
            mac_pkt_len  <= '0;
        end else begin
            case (state)
                S_IDLE: if (!tx_enable) cur_ptr <= ring_base;
                S_RD_CTRL: begin
                    ctrl_q <= ctrl_dec;
                    if (ctrl_dec.first) begin
                        frame_cnt    <= '0;
                        mac_crc_en   <= ctrl_dec.crc;
                        mac_retry_lc <= ctrl_dec.retry_lc;
                        mac_pkt_len  <= ctrl_dec.pkt_len;
                    end
                end
                S_RD_BUF: begin
                    buf_q <= mem_rdata[AW-1:0];
                    idx   <= '0;
                end
                S_RD_NEXT: next_q <= mem_rdata[AW-1:0];
                S_STREAM: if (mac_ready) begin
                    idx       <= idx + 1'b1;
                    frame_cnt <= cnt_inc;
                end
                S_PAD: if (mac_ready) frame_cnt <= cnt_inc;
                S_WAIT_MAC: if (mac_done) begin
                    res_q.coll         <= mac_coll_cnt;
                    res_q.late_col     <= mac_late_col;
                    res_q.carrier_lost <= mac_carrier_lost;
                    res_q.underflow    <= mac_underflow;
                end
                S_WR_STAT: cur_ptr <= next_q;
                default: ;
            endcase
        end
    end

    // R1: idle after reset
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!mac_valid && !mem_we));

    // R2: disabled engine stays idle
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !tx_enable) |=> (state == S_IDLE));

    // R3: a host-owned descriptor sends the engine home
    a_r3_unavail_home: assert property (@(posedge clk) disable iff (!rst_n)
        tx_buf_unavail |=> (state == S_IDLE));

    // R5: byte held while MAC stalls
    a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_data) && $stable(mac_last)));

    // R6: padded frame never ends short
    a_r6_pad_len: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && mac_ready && mac_last && ctrl_q.pad) |-> (frame_cnt >= MIN_LAST));

    // R8: write-back always returns ownership to the host
    a_r8_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_wdata[OWN_BIT]);

    // R9: done pulse coincides with a write-back
    a_r9_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> mem_we);

    // R10: early pulse only with an accepted byte
    a_r10_early_accept: assert property (@(posedge clk) disable iff (!rst_n)
        tx_early |-> (mac_valid && mac_ready && mac_first == (frame_cnt == '0)));

endmodule

// File: tb/txdesc_engine_bench.sv
module txdesc_engine_bench;
    typedef struct packed {
        logic [10:0] len;
        logic        pad;
        logic [7:0]  coll;
        logic        late;
        logic        csl;
        logic        udf;
        logic [7:0]  rdy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{11'd64, 1'b1, 8'd0,  1'b0, 1'b0, 1'b0, 8'hFF},
        '{11'd10, 1'b1, 8'd3,  1'b0, 1'b0, 1'b0, 8'h55},
        '{11'd10, 1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 8'hFF},
        '{11'd59, 1'b1, 8'd0,  1'b1, 1'b0, 1'b0, 8'hB7},
        '{11'd60, 1'b1, 8'd16, 1'b0, 1'b0, 1'b0, 8'hFF},
        '{11'd1,  1'b1, 8'd15, 1'b0, 1'b1, 1'b1, 8'h33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0, tx_poll = 1'b0;
    logic [31:0] ring_base = 32'd0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic        mac_valid, mac_first, mac_last, mac_crc_en, mac_retry_lc;
    logic [7:0]  mac_data;
    logic [10:0] mac_pkt_len;
    logic        mac_ready = 1'b0, mac_done = 1'b0;
    logic [7:0]  mac_coll_cnt = 8'd0;
    logic        mac_late_col = 1'b0, mac_carrier_lost = 1'b0, mac_underflow = 1'b0;
    logic        tx_done, tx_early, tx_buf_unavail;

    logic [31:0] mem [0:255];
    logic        host_we = 1'b0;
    logic [7:0]  host_idx = 8'd0;
    logic [31:0] host_data = 32'd0;
    logic [7:0]  ready_pat = 8'hFF;
    logic        clr = 1'b0, done_req = 1'b0;

    logic [7:0]  got [0:127];
    int          got_n = 0, first_n = 0, first_at = -1, last_at = -1;
    int          done_n = 0, bu_n = 0, early_n = 0, cyc = 0;
    logic        crc_s = 1'b0, rty_s = 1'b0;
    logic [10:0] pkt_s = 11'd0;
    int          errs = 0, checks = 0;

    always #2 clk = ~clk;

    txdesc_engine u_txdesc_engine (
        .clk, .rst_n, .tx_enable, .tx_poll, .ring_base,
        .mem_addr, .mem_we, .mem_wdata, .mem_rdata,
        .mac_valid, .mac_data, .mac_first, .mac_last, .mac_ready,
        .mac_crc_en, .mac_retry_lc, .mac_pkt_len,
        .mac_done, .mac_coll_cnt, .mac_late_col, .mac_carrier_lost, .mac_underflow,
        .tx_done, .tx_early, .tx_buf_unavail
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else if (host_we) mem[host_idx] <= host_data;
    end

    always @(posedge clk) begin
        if (clr) begin
            got_n <= 0; first_n <= 0; first_at <= -1; last_at <= -1;
            done_n <= 0; bu_n <= 0; early_n <= 0; done_req <= 1'b0;
        end else begin
            if (mac_valid && mac_ready) begin
                if (got_n < 128) got[got_n[6:0]] <= mac_data;
                if (mac_first) begin
                    first_n  <= first_n + 1;
                    first_at <= got_n;
                    crc_s    <= mac_crc_en;
                    rty_s    <= mac_retry_lc;
                    pkt_s    <= mac_pkt_len;
                end
                if (mac_last) last_at <= got_n;
                got_n <= got_n + 1;
            end
            if (tx_done) done_n <= done_n + 1;
            if (tx_buf_unavail) bu_n <= bu_n + 1;
            if (tx_early) early_n <= early_n + 1;
            if (mac_done) done_req <= 1'b0;
            else if (mac_valid && mac_ready && mac_last) done_req <= 1'b1;
        end
    end

    always @(negedge clk) begin
        cyc       <= cyc + 1;
        mac_ready <= ready_pat[cyc[2:0]];
        mac_done  <= done_req;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_idx = addr[9:2]; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input logic irq, early, last, first, crc, pad,
                                        retry, input logic [10:0] pkt, bcnt);
        return {irq, early, last, first, crc, pad, retry, 3'b000, pkt, bcnt};
    endfunction

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 13 + seed) & 255);
    endfunction

    task automatic desc(input int a, input logic own, input logic [31:0] c,
                        input int b, input int nx);
        wr(a,      {own, 31'd0});
        wr(a + 4,  c);
        wr(a + 8,  32'(b));
        wr(a + 12, 32'(nx));
    endtask

    task automatic fill(input int a, input int n, input int seed);
        for (int w = 0; w < (n + 3) / 4; w++)
            wr(a + 4 * w, {pat(4*w+3, seed), pat(4*w+2, seed), pat(4*w+1, seed), pat(4*w, seed)});
    endtask

    task automatic set_ring(input int base);
        @(negedge clk);
        tx_enable = 1'b0; ring_base = 32'(base);
        repeat (3) @(negedge clk);
        tx_enable = 1'b1;
    endtask

    task automatic run();
        int t;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; tx_poll = 1'b1;
        @(negedge clk); tx_poll = 1'b0;
        t = 0;
        while (bu_n == 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int bad, exp_n;
        logic [31:0] exp_st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", int'(mac_valid), 0);
        chk("R1 we", int'(mem_we), 0);
        chk("R1 pulses", int'({tx_done, tx_early, tx_buf_unavail}), 0);

        // R2: poll ignored while disabled
        desc(0, 1'b1, ctl(1,0,1,1,1,1,0,11'd8,11'd8), 'h100, 0);
        fill('h100, 8, 0);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        tx_poll = 1'b1; @(negedge clk); tx_poll = 1'b0;
        repeat (20) @(negedge clk);
        chk("R2 bytes", got_n, 0);
        chk("R2 own kept", int'(mem[0][31]), 1);
        chk("R2 no unavail", bu_n, 0);

        // R3: host-owned descriptor
        wr(0, 32'd0);
        set_ring(0);
        run();
        chk("R3 unavail", bu_n, 1);
        chk("R3 bytes", got_n, 0);

        // R11, R4, R7, R8, R9: two-descriptor chain
        ready_pat = 8'h6D;
        mac_coll_cnt = 8'd2;
        desc('h00, 1'b1, ctl(0,0,0,1,1,0,0,11'd50,11'd20), 'h100, 'h10);
        desc('h10, 1'b1, ctl(1,0,1,0,0,0,0,11'd0,11'd30),  'h180, 'h20);
        desc('h20, 1'b0, 32'd0, 'h100, 'h00);
        fill('h100, 20, 1);
        fill('h180, 30, 5);
        set_ring(0);
        run();
        chk("R11 chain bytes", got_n, 50);
        bad = 0;
        for (int k = 0; k < 20; k++) if (got[k] != pat(k, 1)) bad++;
        for (int k = 0; k < 30; k++) if (got[20+k] != pat(k, 5)) bad++;
        chk("R5 chain data", bad, 0);
        chk("R7 chain first", first_n, 1);
        chk("R7 chain last", last_at, 49);
        chk("R8 non-last status", int'(mem[0]), 0);
        chk("R8 last status", int'(mem[4]), 2);
        chk("R9 chain done", done_n, 1);
        chk("R11 unavail at end", bu_n, 1);

        // R2 base reload, R6: zero-length padded frame (pointer was left at 0x20)
        ready_pat = 8'hFF;
        mac_coll_cnt = 8'd0;
        desc(0, 1'b1, ctl(1,0,1,1,0,1,0,11'd0,11'd0), 'h100, 0);
        set_ring(0);
        run();
        chk("R2 reload / R6 pad count", got_n, 60);
        bad = 0;
        for (int k = 0; k < 60; k++) if (got[k] != 8'd0) bad++;
        chk("R6 pad zeros", bad, 0);
        chk("R7 pad last", last_at, 59);

        // R10, R12, R9: early bit, no done bit, forwarded flags
        desc(0, 1'b1, ctl(0,1,1,1,1,0,1,11'd77,11'd5), 'h100, 0);
        fill('h100, 5, 9);
        set_ring(0);
        run();
        chk("R10 early", early_n, 1);
        chk("R9 no irq", done_n, 0);
        chk("R12 crc", int'(crc_s), 1);
        chk("R12 retry", int'(rty_s), 1);
        chk("R12 pkt", int'(pkt_s), 77);
        chk("R5 count", got_n, 5);

        // Vector table: R5 R6 R7 R8 R9 R11
        for (int v = 0; v < NV; v++) begin
            ready_pat        = VEC[v].rdy;
            mac_coll_cnt     = VEC[v].coll;
            mac_late_col     = VEC[v].late;
            mac_carrier_lost = VEC[v].csl;
            mac_underflow    = VEC[v].udf;
            desc(0, 1'b1, ctl(1,0,1,1,1,VEC[v].pad,0,VEC[v].len,VEC[v].len), 'h100, 0);
            fill('h100, int'(VEC[v].len), v);
            set_ring(0);
            run();
            exp_n = (VEC[v].pad && VEC[v].len < 11'd60) ? 60 : int'(VEC[v].len);
            chk("R6 length", got_n, exp_n);
            bad = 0;
            for (int k = 0; k < exp_n; k++)
                if (got[k] != ((k < int'(VEC[v].len)) ? pat(k, v) : 8'd0)) bad++;
            chk("R5 data", bad, 0);
            chk("R7 first", first_at, 0);
            chk("R7 last", last_at, exp_n - 1);
            exp_st = (32'(VEC[v].csl) << 13) | (32'(VEC[v].late) << 12) |
                     (32'(VEC[v].coll >= 8'd16) << 11) | (32'(VEC[v].udf) << 10) |
                     32'(VEC[v].coll);
            chk("R8 status", int'(mem[0]), int'(exp_st));
            chk("R9 done", done_n, 1);
            chk("R11 unavail", bu_n, 1);
            chk("R10 no early", early_n, 0);
        end

        summary();
        $finish;
    end
endmodule